// File: doc/BRIEF.md
# Keyed Substitution Table Generator

This block turns a 128-bit secret key into a private pair of byte substitution tables for a block cipher datapath. Every entry of the standard AES forward S-box is perturbed by a key-dependent mask: the key byte assigned to that index is ANDed with a fixed 8-bit secret constant, and the result is XORed onto the standard value. The perturbed table is stored in a forward RAM. The inverse table is stored in a second RAM by writing each index at the address given by its perturbed value. Encryption rounds use the forward table for every state byte. Decryption rounds use the inverse table, not the standard inverse S-box.

A single-cycle `start` pulse latches the key. The block then processes one index per clock, from 0 up to 255, and raises `done` for one cycle after the last index. Both tables have a registered read port for the cipher datapath. Reads return zero while generation runs. Some keys make the perturbed mapping non-bijective. The block detects this by keeping a 256-bit record of the inverse slots already written, and it raises a sticky `collision` flag when a slot is hit a second time. The tables must be regenerated whenever the key changes.

Top module: `sbox_keyed_gen`

## Requirements
- R1: After synchronous reset, `busy`, `done` and `collision` are all 0.
- R2: A `start` sampled high while `busy` is low makes `busy` high from the next cycle for exactly 256 cycles. In that window the block processes indices 0, 1, ..., 255, one per cycle.
- R3: `done` is high for exactly one cycle, the cycle after index 255 is processed, and `busy` is low in that cycle.
- R4: After generation, forward entry i equals S(i) XOR (MASK_CONST AND k), where S is the standard AES S-box (S(0)=0x63, S(1)=0x7C) and k is key byte (i mod 16). Key byte 0 is `key[127:120]`.
- R5: After generation, inverse entry v holds the last index i whose forward entry equals v. For a bijective mapping, `inv[fwd[i]] == i` for every i.
- R6: `collision` is set when an inverse slot is written a second time within one generation. It stays set until the next accepted `start`, which clears it.
- R7: A read whose address is sampled while `busy` is high returns 0.
- R8: Read data appears on `fwd_rdata` / `inv_rdata` in the cycle after the address is sampled.
- R9: A `start` pulse while `busy` is high is ignored: the index sequence and `busy` continue unchanged.
- R10: The key is sampled only when `start` is accepted. Changing `key` during generation has no effect on the tables.
- R11: An all-zero key yields exactly the standard S-box and its standard inverse, with no collision. A key whose bytes are all equal also yields a permutation, with no collision.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin regenerating both tables from `key` |
| key | input | 128 | Secret key; byte 0 is the top byte |
| busy | output | 1 | Generation in progress |
| done | output | 1 | One-cycle pulse when generation ends |
| collision | output | 1 | Sticky flag: the mapping is not a permutation |
| fwd_raddr | input | 8 | Forward table read address |
| fwd_rdata | output | 8 | Forward table read data, one cycle later |
| inv_raddr | input | 8 | Inverse table read address |
| inv_rdata | output | 8 | Inverse table read data, one cycle later |

## Verification
The bench builds the block with MASK_CONST = 0xC3 and the default 16 key bytes. A mask with both high and low bits set lets varied key bytes move entries onto each other, which produces real collisions and overwritten inverse slots. The bench also uses an all-zero key and a uniform all-0xFF key, which bring the bijective corner within reach, and random read addresses reach the zero-while-busy rule. Back-to-back starts, including one issued in the `done` cycle, and start or key changes mid-run exercise the sampling rules.

// File: rtl/sbg_pkg.sv
package sbg_pkg;

    localparam int BYTE_W   = 8;
    localparam int TBL_AW   = BYTE_W;
    localparam int TBL_SIZE = 1 << TBL_AW;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [1:0] {
        GEN_IDLE = 2'd0,
        GEN_RUN  = 2'd1,
        GEN_FIN  = 2'd2
    } gen_state_e;

    // One table update: forward[idx] <= val, inverse[val] <= idx
    typedef struct packed {
        logic  en;
        byte_t idx;
        byte_t val;
    } tbl_wr_t;

    // Multiply by x in GF(2^8) modulo x^8+x^4+x^3+x+1
    function automatic byte_t gf_xtime(byte_t a);
        return {a[BYTE_W-2:0], 1'b0} ^ (a[BYTE_W-1] ? 8'h1B : 8'h00);
    endfunction

    function automatic byte_t gf_mul(byte_t a, byte_t b);
        byte_t acc = '0;
        byte_t run = a;
        for (int k = 0; k < BYTE_W; k++) begin
            if (b[k]) acc = acc ^ run;
            run = gf_xtime(run);
        end
        return acc;
    endfunction

    // a^254 is the multiplicative inverse (0 maps to 0)
    function automatic byte_t gf_inv(byte_t a);
        byte_t sq  = a;
        byte_t res = 8'h01;
        for (int k = 1; k < BYTE_W; k++) begin
            sq  = gf_mul(sq, sq);
            res = gf_mul(res, sq);
        end
        return res;
    endfunction

    function automatic byte_t rotl(byte_t a, int n);
        return byte_t'((a << n) | (a >> (BYTE_W - n)));
    endfunction

    // Standard AES forward S-box, computed rather than tabulated
    function automatic byte_t aes_sbox(byte_t a);
        byte_t b = gf_inv(a);
        return b ^ rotl(b, 1) ^ rotl(b, 2) ^ rotl(b, 3) ^ rotl(b, 4) ^ 8'h63;
    endfunction

endpackage

// File: rtl/sbg_entry_calc.sv
module sbg_entry_calc
    import sbg_pkg::*;
#(
    parameter byte_t MASK_CONST = 8'h5A,
    parameter int    KEY_BYTES  = 16
) (
    input  byte_t                        idx,
    input  logic [KEY_BYTES*BYTE_W-1:0]  key,
    output byte_t                        entry
);
    localparam int KEY_W = KEY_BYTES * BYTE_W;
    localparam int SEL_W = $clog2(KEY_BYTES);

    byte_t            kb [KEY_BYTES];
    logic [SEL_W-1:0] sel;

    // Byte 0 of the key is its most significant byte
    for (genvar g = 0; g < KEY_BYTES; g++) begin : g_kbyte
        assign kb[g] = key[KEY_W-1-g*BYTE_W -: BYTE_W];
    end

    assign sel   = SEL_W'(int'(idx) % KEY_BYTES);
    assign entry = aes_sbox(idx) ^ (MASK_CONST & kb[sel]);

endmodule

// File: rtl/sbg_table_ram.sv
module sbg_table_ram #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    input  logic          rd_block,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        rdata <= rd_block ? '0 : mem[raddr];
    end

endmodule

// File: rtl/sbg_seen_track.sv
module sbg_seen_track #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          mark,
    input  logic [AW-1:0] slot,
    output logic          collision
);
    localparam int DEPTH = 1 << AW;

    logic [DEPTH-1:0] seen_q;
    logic             coll_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            seen_q <= '0;
            coll_q <= 1'b0;
        end else if (mark) begin
            if (seen_q[slot]) coll_q <= 1'b1;
            seen_q[slot] <= 1'b1;
        end
    end

    assign collision = coll_q;

    // R6
    dup_slot_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (mark && !clear && seen_q[slot]) |=> collision);

    // R6
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (collision && !clear) |=> collision);

endmodule

// File: rtl/sbox_keyed_gen.sv
module sbox_keyed_gen
    import sbg_pkg::*;
#(
    parameter byte_t MASK_CONST = 8'h5A,
    parameter int    KEY_BYTES  = 16
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        start,
    input  logic [KEY_BYTES*BYTE_W-1:0] key,
    output logic                        busy,
    output logic                        done,
    output logic                        collision,
    input  logic [TBL_AW-1:0]           fwd_raddr,
    output logic [BYTE_W-1:0]           fwd_rdata,
    input  logic [TBL_AW-1:0]           inv_raddr,
    output logic [BYTE_W-1:0]           inv_rdata
);
    localparam int    KEY_W    = KEY_BYTES * BYTE_W;
    localparam byte_t LAST_IDX = byte_t'(TBL_SIZE - 1);

    gen_state_e        state_q;
    byte_t             idx_q;
    logic [KEY_W-1:0]  key_q;
    logic              start_go;
    logic              busy_w;
    byte_t             entry;
    tbl_wr_t           wr;

    assign busy_w   = (state_q == GEN_RUN);
    assign start_go = start && !busy_w;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= GEN_IDLE;
            idx_q   <= '0;
            key_q   <= '0;
        end else begin
            case (state_q)
                GEN_RUN: begin
                    idx_q <= idx_q + 1'b1;
                    if (idx_q == LAST_IDX) state_q <= GEN_FIN;
                end
                default: begin
                    if (start_go) begin
                        state_q <= GEN_RUN;
                        idx_q   <= '0;
                        key_q   <= key;
                    end else begin
                        state_q <= GEN_IDLE;
                    end
                end
            endcase
        end
    end

    sbg_entry_calc #(
        .MASK_CONST (MASK_CONST),
        .KEY_BYTES  (KEY_BYTES)
    ) u_calc (
        .idx   (idx_q),
        .key   (key_q),
        .entry (entry)
    );

    assign wr = '{en: busy_w, idx: idx_q, val: entry};

    sbg_table_ram #(.AW(TBL_AW), .DW(BYTE_W)) u_fwd_ram (
        .clk      (clk),
        .we       (wr.en),
        .waddr    (wr.idx),
        .wdata    (wr.val),
        .raddr    (fwd_raddr),
        .rd_block (busy_w),
        .rdata    (fwd_rdata)
    );

    sbg_table_ram #(.AW(TBL_AW), .DW(BYTE_W)) u_inv_ram (
        .clk      (clk),
        .we       (wr.en),
        .waddr    (wr.val),
        .wdata    (wr.idx),
        .raddr    (inv_raddr),
        .rd_block (busy_w),
        .rdata    (inv_rdata)
    );

    sbg_seen_track #(.AW(TBL_AW)) u_seen (
        .clk       (clk),
        .rst       (rst),
        .clear     (start_go),
        .mark      (wr.en),
        .slot      (wr.val),
        .collision (collision)
    );

    assign busy = busy_w;
    assign done = (state_q == GEN_FIN);

    // R2
    run_begins_on_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));

    // R2 R9
    index_steps_by_one_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && idx_q != LAST_IDX) |=> (busy && idx_q == $past(idx_q) + 1'b1));

    // R3
    done_after_last_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && idx_q == LAST_IDX) |=> (done && !busy));

    // R3
    done_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7
    read_zero_while_busy_chk: assert property (@(posedge clk) disable iff (rst)
        $past(busy) |-> (fwd_rdata == '0 && inv_rdata == '0));

    // R10
    key_held_during_run_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && idx_q != LAST_IDX) |=> $stable(key_q));

endmodule

// File: tb/sbox_keyed_gen_bench.sv
`timescale 1ns/1ps
module sbox_keyed_gen_bench;

    localparam logic [7:0] MASK = 8'hC3;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [127:0] key = '0;
    logic [7:0]   fwd_raddr = '0;
    logic [7:0]   inv_raddr = '0;
    logic         busy, done, collision;
    logic [7:0]   fwd_rdata, inv_rdata;

    always #2.5 clk = ~clk;

    sbox_keyed_gen #(.MASK_CONST(MASK), .KEY_BYTES(16)) u_sbox_keyed_gen (
        .clk(clk), .rst(rst), .start(start), .key(key),
        .busy(busy), .done(done), .collision(collision),
        .fwd_raddr(fwd_raddr), .fwd_rdata(fwd_rdata),
        .inv_raddr(inv_raddr), .inv_rdata(inv_rdata)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    task automatic chk(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Standard S-box built by walking the field with generator 3
    logic [7:0] std_sbox [256];
    initial begin
        logic [7:0] p, q, x;
        p = 8'h01; q = 8'h01;
        do begin
            p = p ^ {p[6:0], 1'b0} ^ (p[7] ? 8'h1B : 8'h00);
            q = q ^ {q[6:0], 1'b0};
            q = q ^ {q[5:0], 2'b00};
            q = q ^ {q[3:0], 4'h0};
            if (q[7]) q = q ^ 8'h09;
            x = q ^ {q[6:0], q[7]} ^ {q[5:0], q[7:6]} ^ {q[4:0], q[7:5]} ^ {q[3:0], q[7:4]};
            std_sbox[p] = x ^ 8'h63;
        end while (p != 8'h01);
        std_sbox[0] = 8'h63;
    end

    function automatic logic [7:0] key_byte(logic [127:0] k, int i);
        return k[127 - 8*(i % 16) -: 8];
    endfunction

    // Reference model, advanced on every rising edge
    bit         m_busy = 0, m_done = 0, m_coll = 0;
    int         m_idx = 0;
    logic [127:0] m_key = '0;
    logic [7:0] ref_fwd [256];
    logic [7:0] ref_inv [256];
    bit         f_known [256];
    bit         i_known [256];
    bit         seen    [256];
    logic [7:0] ef, ei;
    bit         ef_ok = 0, ei_ok = 0, ef_blk = 0;
    bit         mon_on = 0;

    initial for (int i = 0; i < 256; i++) begin f_known[i] = 0; i_known[i] = 0; seen[i] = 0; end

    always @(posedge clk) begin
        if (rst) begin
            m_busy = 0; m_done = 0; m_coll = 0; ef_ok = 0; ei_ok = 0;
        end else begin
            ef_blk = m_busy;
            ef_ok  = m_busy || f_known[fwd_raddr];
            ei_ok  = m_busy || i_known[inv_raddr];
            ef     = m_busy ? 8'h00 : ref_fwd[fwd_raddr];
            ei     = m_busy ? 8'h00 : ref_inv[inv_raddr];
            m_done = 0;
            if (m_busy) begin
                logic [7:0] e;
                e = std_sbox[m_idx] ^ (MASK & key_byte(m_key, m_idx));
                ref_fwd[m_idx] = e; f_known[m_idx] = 1;
                if (seen[e]) m_coll = 1;
                seen[e] = 1;
                ref_inv[e] = 8'(m_idx); i_known[e] = 1;
                if (m_idx == 255) begin m_busy = 0; m_done = 1; end
                else m_idx++;
            end else if (start) begin
                m_busy = 1; m_idx = 0; m_key = key; m_coll = 0;
                for (int i = 0; i < 256; i++) seen[i] = 0;
            end
        end
    end

    // Per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (mon_on && !rst) begin
            chk("R2 busy", busy, m_busy);
            chk("R3 done", done, m_done);
            chk("R6 collision", collision, m_coll);
            // R8: data for the address sampled at the last edge
            if (ef_ok) chk(ef_blk ? "R7 fwd" : "R4 fwd", fwd_rdata, ef);
            if (ei_ok) chk(ef_blk ? "R7 inv" : "R5 inv", inv_rdata, ei);
        end
    end

    task automatic pulse_start(logic [127:0] k);
        @(negedge clk); key = k; start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic idle_reads(int n);
        for (int c = 0; c < n; c++) begin
            @(negedge clk);
            fwd_raddr = 8'($urandom);
            inv_raddr = 8'($urandom);
        end
    endtask

    task automatic wait_done();
        int guard = 0;
        while (!done && guard < 400) begin
            @(negedge clk);
            fwd_raddr = 8'($urandom);
            inv_raddr = 8'($urandom);
            guard++;
        end
        chk("R3 done seen", done, 1);
    endtask

    // mode 0: model only; 1: standard table; 2: uniform key 0xFF
    task automatic sweep(int mode);
        @(negedge clk); fwd_raddr = 8'd0; inv_raddr = 8'd0;
        for (int i = 0; i < 256; i++) begin
            @(negedge clk);
            if (mode == 1) begin
                chk("R11 fwd std", fwd_rdata, std_sbox[i]);
                chk("R11 inv std", std_sbox[inv_rdata], i);
            end else if (mode == 2) begin
                chk("R4 fwd uniform", fwd_rdata, std_sbox[i] ^ MASK);
                chk("R5 inv uniform", std_sbox[inv_rdata] ^ MASK, i);
            end
            if (i < 255) begin fwd_raddr = 8'(i + 1); inv_raddr = 8'(i + 1); end
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        mon_on = 1;
        @(negedge clk);
        // R1
        chk("R1 busy", busy, 0);
        chk("R1 done", done, 0);
        chk("R1 collision", collision, 0);

        // R11: zero key gives the standard S-box, reads blocked while busy (R7)
        pulse_start('0);
        chk("R2 busy after start", busy, 1);
        wait_done();
        chk("R11 no collision", collision, 0);
        sweep(1);

        // R11 / R4: uniform key is a pure XOR offset, still a permutation
        pulse_start({16{8'hFF}});
        wait_done();
        chk("R11 uniform no collision", collision, 0);
        sweep(2);

        // R9 / R10: extra starts and a key change during the run
        pulse_start(128'h0F1E2D3C4B5A69788796A5B4C3D2E1F0);
        idle_reads(20);
        @(negedge clk); start = 1'b1; key = 128'hDEADBEEF_01234567_89ABCDEF_CAFEF00D;
        @(negedge clk); start = 1'b0;
        idle_reads(50);
        key = '1;
        wait_done();
        sweep(0);

        // R6: start issued in the done cycle clears the flag and restarts
        pulse_start(128'h00112233445566778899AABBCCDDEEFF);
        wait_done();
        chk("R6 flag matches model", collision, m_coll);
        start = 1'b1; key = '0;
        @(negedge clk); start = 1'b0;
        chk("R6 cleared on restart", collision, 0);
        chk("R2 restart busy", busy, 1);
        wait_done();
        sweep(1);
        idle_reads(4);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule